// File: doc/BRIEF.md
# Packetized OTP Read Controller

This block fronts a one-time-programmable word array whose contents are laid out as a chain of variable-length packets. Each packet starts with a 32-bit header. Bits 15:8 of the header carry a size field N, and the packet holds N+1 payload words after its header, so it spans N+2 words in total. A header whose size field is zero ends the chain.

Software writes a word address into the mode register and then sets the start bit in the control register. The controller walks the headers from word 0, one header per cycle, until it finds the packet whose word range contains the requested address. It latches that header into the header register and copies the payload, one word per cycle, into a local buffer. Software then reads the payload through an index/data register pair.

A load port writes the behavioural array image, and stands in for a fused array. If the request lies past the last valid packet, the controller flags an error and loads no data.

Top module: `otp_packet_reader`

## Requirements
- R1: After reset, the status register (0x0C) reads 0, the header register (0x20) reads 0, and the payload data register (0x24) reads 0.
- R2: A write to the control register (0x00) with bit 6 set starts a packet read while the block is idle, and status bit 6 (busy) reads 1 from the cycle after that write. A control write with bit 6 clear starts nothing.
- R3: The packet at start word S with size field N (header bits 15:8) covers words S to S+N+1. A request for any word in that range loads that packet's header into the header register (0x20).
- R4: A write to the payload index register (0x08) sets the index to bits 8:0 of the written value, and reads of 0x08 return the index. Each read of 0x24 returns payload word number index, and then increments the index. A new start resets the index to 0.
- R5: A read of 0x24 with an index greater than N returns 0. The index stops at 256 and does not wrap.
- R6: A request whose address lies at or beyond the terminating header (size field 0), or beyond the array, sets status bit 1. In that case the header register reads 0, payload reads return 0, and busy lasts P+1 cycles for P valid packets. The next start clears status bit 1.
- R7: When the request hits packet number k (counting from 0) with size field N, busy reads 1 for exactly k+N+2 consecutive cycles.
- R8: A start written while busy is ignored. The running read keeps the address latched at its own start.
- R9: The mode register (0x04) holds the requested word address in bits 31:16 and reads back that field, with bits 15:0 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the payload index on 0x24) |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ld_en | input | 1 | Array image load strobe |
| ld_addr | input | 16 | Array word address to load |
| ld_data | input | 32 | Array word to load |

## Verification
The assertions take two things for granted. Software polls busy before it touches the payload registers, and it does not rewrite the array image while a walk or copy is in progress. The stimulus loads each layout completely before the first request, and it waits for busy to fall after every start. The only exception is the deliberate start-while-busy case, which writes only control and mode during the busy window. Packet layouts use random size fields of at least 1 and random header and payload bits. A directed layout adds a maximum-size packet and a minimum-size packet, and requests hit the first word, the last word and random interior words of packets, as well as addresses on and past the terminator.

// File: rtl/otp_packet_reader.sv
module otp_packet_reader #(
  parameter int ARRAY_WORDS = 2816,
  parameter int SZW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ld_en,
  input  logic [15:0] ld_addr,
  input  logic [31:0] ld_data
);
  localparam int AW = $clog2(ARRAY_WORDS);
  localparam int BUF_WORDS = 1 << SZW;
  localparam int IW = SZW + 1;
  localparam logic [16:0] LIMIT = 17'(ARRAY_WORDS);
  localparam logic [IW-1:0] IDX_END = IW'(BUF_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_COPY} st_t;

  logic [31:0] mem [ARRAY_WORDS];
  logic [31:0] buf_q [BUF_WORDS];

  st_t            st_q;
  logic [16:0]    pos_q, base_q;
  logic [15:0]    mode_q, req_q;
  logic [31:0]    hdr_q;
  logic [SZW-1:0] size_q, cnt_q;
  logic [IW-1:0]  idx_q;
  logic           err_q, ok_q;

  wire busy     = (st_q != S_IDLE);
  wire start_wr = bus_wr && bus_addr == 6'h00 && bus_wdata[6];
  wire idx_wr   = bus_wr && bus_addr == 6'h08;
  wire pd_rd    = bus_rd && bus_addr == 6'h24;

  wire [31:0]    walk_word = (pos_q < LIMIT) ? mem[pos_q[AW-1:0]] : 32'd0;
  wire [SZW-1:0] walk_n    = walk_word[8+SZW-1:8];
  wire [16:0]    next_pos  = pos_q + 17'(walk_n) + 17'd2;
  wire [16:0]    copy_addr = base_q + 17'(cnt_q);
  wire [31:0]    copy_word = (copy_addr < LIMIT) ? mem[copy_addr[AW-1:0]] : 32'd0;

  always_ff @(posedge clk)
    if (ld_en && {1'b0, ld_addr} < LIMIT) mem[ld_addr[AW-1:0]] <= ld_data;

  always_ff @(posedge clk)
    if (st_q == S_COPY) buf_q[cnt_q] <= copy_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; pos_q <= '0; base_q <= '0; mode_q <= '0; req_q <= '0;
      hdr_q <= '0; size_q <= '0; cnt_q <= '0; idx_q <= '0; err_q <= 1'b0; ok_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 6'h04) mode_q <= bus_wdata[31:16];
      if (idx_wr) idx_q <= bus_wdata[IW-1:0];
      else if (pd_rd && idx_q != IDX_END) idx_q <= idx_q + 1'b1;
      case (st_q)
        S_IDLE:
          if (start_wr) begin
            st_q <= S_WALK; pos_q <= '0; req_q <= mode_q;
            err_q <= 1'b0; ok_q <= 1'b0; idx_q <= '0;
          end
        S_WALK:
          if (walk_n == '0) begin
            st_q <= S_IDLE; err_q <= 1'b1; hdr_q <= '0;
          end else if ({1'b0, req_q} < next_pos) begin
            st_q <= S_COPY; hdr_q <= walk_word; size_q <= walk_n;
            base_q <= pos_q + 17'd1; cnt_q <= '0;
          end else pos_q <= next_pos;
        S_COPY: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == size_q) begin
            st_q <= S_IDLE; ok_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      6'h04:   bus_rdata = {mode_q, 16'd0};
      6'h08:   bus_rdata = 32'(idx_q);
      6'h0C:   bus_rdata = {25'd0, busy, 4'd0, err_q, 1'b0};
      6'h20:   bus_rdata = hdr_q;
      6'h24:   bus_rdata = (ok_q && idx_q <= IW'(size_q)) ? buf_q[idx_q[SZW-1:0]] : 32'd0;
      default: bus_rdata = 32'd0;
    endcase
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !busy) |=> busy);
  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && busy) |=> $stable(req_q));
  // R6
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $fell(busy));
  // R3
  hit_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !err_q) |-> hdr_q[8+SZW-1:8] != '0);
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_rd && !idx_wr && !(start_wr && !busy) && idx_q != IDX_END) |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: tb/otp_packet_reader_tb.sv
module otp_packet_reader_tb;
  localparam int WORDS = 2816;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ld_en = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [31:0] ld_data = '0;

  int errors = 0, checks = 0;
  logic [31:0] img [WORDS];
  int st [16];
  int nf [16];
  int npk;

  otp_packet_reader u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic pop, output logic [31:0] d);
    bus_addr = a; bus_rd = pop;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic void build(input int n, input int sz0, input int sz1);
    int p = 0;
    for (int i = 0; i < WORDS; i++) img[i] = $urandom;
    npk = n;
    for (int k = 0; k < n; k++) begin
      int f;
      f = (k == 0 && sz0 > 0) ? sz0 : (k == 1 && sz1 > 0) ? sz1 : 1 + ($urandom % 12);
      st[k] = p; nf[k] = f;
      img[p] = {16'($urandom), 8'(f), 8'($urandom)};
      p += f + 2;
    end
    st[n] = p;
    img[p] = {16'($urandom), 8'd0, 8'($urandom)};
  endfunction

  function automatic int find_pkt(input int a);
    for (int k = 0; k < npk; k++) if (a >= st[k] && a < st[k] + nf[k] + 2) return k;
    return -1;
  endfunction

  task automatic load_image();
    for (int i = 0; i < WORDS; i++) begin
      ld_en = 1'b1; ld_addr = 16'(i); ld_data = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic request(input int a, output int cyc);
    logic [31:0] s;
    wr(6'h04, {16'(a), 16'h0});
    wr(6'h00, 32'h40);
    cyc = 0;
    rd(6'h0C, 1'b0, s);
    while (s[6] && cyc < 2000) begin
      cyc++;
      rd(6'h0C, 1'b0, s);
    end
  endtask

  task automatic hit(input int a, input logic full);
    int k, cyc;
    logic [31:0] d;
    k = find_pkt(a);
    request(a, cyc);
    chk("R7", "busy cycles", 32'(cyc), 32'(k + nf[k] + 2));
    rd(6'h0C, 1'b0, d);
    chk("R6", "status after hit", d, 32'h0);
    rd(6'h20, 1'b0, d);
    chk("R3", "header", d, img[st[k]]);
    if (full) begin
      for (int j = 0; j <= nf[k]; j++) begin
        rd(6'h24, 1'b1, d);
        chk("R4", "payload word", d, img[st[k] + 1 + j]);
      end
      rd(6'h24, 1'b1, d);
      chk("R5", "past payload end", d, 32'h0);
    end else begin
      int j;
      j = $urandom % (nf[k] + 1);
      wr(6'h08, 32'(j));
      rd(6'h24, 1'b1, d);
      chk("R4", "indexed payload", d, img[st[k] + 1 + j]);
      rd(6'h08, 1'b0, d);
      chk("R4", "index advanced", d, 32'(j + 1));
    end
  endtask

  task automatic miss(input int a);
    int cyc;
    logic [31:0] d;
    request(a, cyc);
    chk("R6", "busy cycles on miss", 32'(cyc), 32'(npk + 1));
    rd(6'h0C, 1'b0, d);
    chk("R6", "error bit", d, 32'h2);
    rd(6'h20, 1'b0, d);
    chk("R6", "header after miss", d, 32'h0);
    rd(6'h24, 1'b1, d);
    chk("R6", "payload after miss", d, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc;
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(6'h0C, 1'b0, d); chk("R1", "status at reset", d, 32'h0);
    rd(6'h20, 1'b0, d); chk("R1", "header at reset", d, 32'h0);
    rd(6'h24, 1'b0, d); chk("R1", "payload at reset", d, 32'h0);

    wr(6'h04, 32'hABCD_1234);
    rd(6'h04, 1'b0, d); chk("R9", "mode readback", d, 32'hABCD_0000);

    wr(6'h00, 32'hFFFF_FFBF);
    rd(6'h0C, 1'b0, d); chk("R2", "no start without bit 6", d, 32'h0);

    build(5, 0, 0);
    load_image();
    for (int k = 0; k < npk; k++) begin
      hit(st[k], 1'b1);
      hit(st[k] + nf[k] + 1, 1'b0);
      hit(st[k] + ($urandom % (nf[k] + 2)), 1'b0);
    end
    for (int r = 0; r < 20; r++) hit($urandom % st[npk], 1'b0);
    miss(st[npk]);
    miss(st[npk] + 1 + ($urandom % 100));
    hit(st[2], 1'b0);
    rd(6'h0C, 1'b0, d); chk("R6", "error cleared by new start", d, 32'h0);

    // R8: second start while busy must not redirect the read
    wr(6'h04, {16'(st[3]), 16'h0});
    wr(6'h00, 32'h40);
    wr(6'h04, {16'(st[0]), 16'h0});
    wr(6'h00, 32'h40);
    cyc = 2;
    rd(6'h0C, 1'b0, d);
    while (d[6] && cyc < 2000) begin cyc++; rd(6'h0C, 1'b0, d); end
    chk("R8", "busy length unchanged", 32'(cyc), 32'(3 + nf[3] + 2));
    rd(6'h20, 1'b0, d); chk("R8", "header of first request", d, img[st[3]]);

    build(4, 255, 1);
    load_image();
    hit(st[0] + 200, 1'b1);
    rd(6'h08, 1'b0, d); chk("R5", "index stops at end", d, 32'd256);
    rd(6'h24, 1'b1, d); chk("R5", "saturated read", d, 32'h0);
    rd(6'h08, 1'b0, d); chk("R5", "index still at end", d, 32'd256);
    wr(6'h08, 32'd255);
    rd(6'h24, 1'b1, d); chk("R4", "last word of max packet", d, img[st[0] + 256]);
    hit(st[1] + 2, 1'b1);
    hit(st[1], 1'b0);
    for (int r = 0; r < 10; r++) hit($urandom % st[npk], 1'b0);
    miss(st[npk] + 5);
    miss(WORDS + 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule